// File: doc/BRIEF.md
# Reentrant Cache-Line Lock Table

This block keeps track of which cache lines are held by an unconditional read-modify-write sequence in a first-level cache. A read-lock request claims the line that contains its address for one thread. A matching write-unlock releases it. The same thread may take the lock on a line again while it already holds it. Each extra take raises the line's nesting depth by one, and the line is freed only when the depth falls back to zero. A lock that is never undone keeps its line held forever.

The cache pipeline uses two combinational lookup ports. The lookup port reports whether a line is held by a thread other than the asking one, together with the line's current depth. The victim port tells an eviction or invalidation that it must not proceed, and tells a flush that it has failed. Requests pass through a three-state controller. In `S_IDLE` the controller accepts a request and moves to `S_DECIDE`. In `S_DECIDE` it updates the table and moves to `S_RESP`. In `S_RESP` it drives a one-cycle response and returns to `S_IDLE`. The only transition that depends on an input is `S_IDLE` to `S_DECIDE`, taken when `req_valid` is high. Each entry of the table holds a valid bit, a line tag, the owning thread and the nesting depth.

Top module: `line_lock_table`

## Requirements
- R1: After reset no line is held, `req_ready` is 1, `rsp_valid` is 0 and every lookup reports depth 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for two cycles. `rsp_valid` is 1 in exactly one cycle, the second one after acceptance, and the table already shows the update in that cycle.
- R3: Only the address bits above the line offset (log2 of `LINE_BYTES`, 6 by default) identify a line. Any two byte addresses inside the same line therefore refer to the same lock.
- R4: A lock (`req_unlock`=0) on a line that is not held, while an entry is free, gives code 0 (OK). The line then has depth 1 and the requesting thread as its owner.
- R5: A lock by the owner of a held line gives code 0 and raises the line's depth by one.
- R6: A lock on a line held by a different thread gives code 3 (HELD) and leaves the table unchanged.
- R7: `lk_foreign` is 1 exactly when the line of `lk_addr` is held by a thread other than `lk_tid`. `lk_depth` gives that line's depth, or 0 if the line is not held.
- R8: An unlock (`req_unlock`=1) by the owner gives code 0 and lowers the depth by one. At depth 0 the line is released.
- R9: An unlock from a thread that does not own the line, or an unlock to a line that is not held, gives code 2 (ERR) and leaves the table unchanged.
- R10: A lock by the owner when the depth is already 2^`CNT_W`-1 gives code 2 (ERR) and leaves the depth unchanged.
- R11: A lock on a line that is not held, while all `N_ENTRIES` entries are in use, gives code 1 (FULL) and leaves the table unchanged.
- R12: With `vt_valid`=1 and `vt_kind` 0 (evict) or 1 (invalidate), `vt_block` is 1 exactly when the line of `vt_addr` is held.
- R13: With `vt_valid`=1 and `vt_kind` 2 (flush), `vt_flush_fail` is 1 exactly when the line is held. `vt_flush_fail` is never 1 for the other kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lock or unlock request present |
| req_unlock | input | 1 | 0 = read-lock, 1 = write-unlock |
| req_addr | input | ADDR_W | Byte address of the request |
| req_tid | input | TID_W | Requesting thread |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 OK, 1 FULL, 2 ERR, 3 HELD |
| lk_addr | input | ADDR_W | Lookup byte address |
| lk_tid | input | TID_W | Lookup thread |
| lk_foreign | output | 1 | Line held by another thread |
| lk_depth | output | CNT_W | Nesting depth of the looked-up line |
| vt_valid | input | 1 | Victim operation present |
| vt_kind | input | 2 | 0 evict, 1 invalidate, 2 flush |
| vt_addr | input | ADDR_W | Victim byte address |
| vt_block | output | 1 | Evict or invalidate must not proceed |
| vt_flush_fail | output | 1 | Flush refused |

## Verification
A wrong owner or tag in an entry appears at the lookup port as a wrong `lk_foreign` or `lk_depth`. This happens in the same cycle the entry changes, which is the response cycle. A depth counter that drifts shows up later, as a premature release or a missed overflow refusal several requests afterwards. For that reason the depth is compared on every clock, not only when the response arrives. A wrong decision in `S_DECIDE` shows directly in `rsp_code` two cycles after acceptance. A stuck controller state shows as `req_ready` or `rsp_valid` out of step in the very next cycle.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [1:0] {
        RSP_OK   = 2'd0,
        RSP_FULL = 2'd1,
        RSP_ERR  = 2'd2,
        RSP_HELD = 2'd3
    } rsp_code_e;

    typedef enum logic [1:0] {
        VT_EVICT = 2'd0,
        VT_INVAL = 2'd1,
        VT_FLUSH = 2'd2
    } vt_kind_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_DECIDE = 2'd1,
        S_RESP   = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/lock_entry.sv
module lock_entry #(
    parameter int TAG_W = 10,
    parameter int TID_W = 2,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_alloc,
    input  logic             do_inc,
    input  logic             do_dec,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [TID_W-1:0] in_tid,
    output logic             valid,
    output logic [TAG_W-1:0] tag,
    output logic [TID_W-1:0] tid,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
            tid   <= '0;
            cnt   <= '0;
        end else if (do_alloc) begin
            valid <= 1'b1;
            tag   <= in_tag;
            tid   <= in_tid;
            cnt   <= ONE;
        end else if (do_inc) begin
            cnt <= cnt + ONE;
        end else if (do_dec) begin
            if (cnt == ONE) begin
                valid <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt - ONE;
            end
        end
    end

    // R8
    cnt_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cnt != '0));

    // R6
    owner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |-> ($stable(tag) && $stable(tid)));

    // R10
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(valid)) |->
        ($stable(cnt) || cnt == $past(cnt) + ONE || cnt == $past(cnt) - ONE));

endmodule

// File: rtl/lock_probe.sv
module lock_probe #(
    parameter int N     = 4,
    parameter int TAG_W = 10,
    parameter int TID_W = 2,
    parameter int CNT_W = 2
) (
    input  logic [TAG_W-1:0]          key,
    input  logic [N-1:0]              e_valid,
    input  logic [N-1:0][TAG_W-1:0]   e_tag,
    input  logic [N-1:0][TID_W-1:0]   e_tid,
    input  logic [N-1:0][CNT_W-1:0]   e_cnt,
    output logic                      hit,
    output logic [N-1:0]              hit_vec,
    output logic [TID_W-1:0]          owner,
    output logic [CNT_W-1:0]          depth
);

    always_comb begin
        hit   = 1'b0;
        owner = '0;
        depth = '0;
        for (int i = 0; i < N; i++) begin
            hit_vec[i] = e_valid[i] && (e_tag[i] == key);
            if (hit_vec[i]) begin
                hit   = 1'b1;
                owner = owner | e_tid[i];
                depth = depth | e_cnt[i];
            end
        end
    end

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
    import lock_pkg::*;
#(
    parameter int N     = 4,
    parameter int TAG_W = 10,
    parameter int TID_W = 2,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_unlock,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TID_W-1:0] req_tid,
    input  logic [N-1:0]     ent_valid,
    input  logic             hit,
    input  logic [N-1:0]     hit_vec,
    input  logic [TID_W-1:0] owner,
    input  logic [CNT_W-1:0] depth,
    output logic [TAG_W-1:0] cap_tag,
    output logic [TID_W-1:0] cap_tid,
    output logic [N-1:0]     ent_alloc,
    output logic [N-1:0]     ent_inc,
    output logic [N-1:0]     ent_dec,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code
);

    localparam logic [CNT_W-1:0] MAX_DEPTH = {CNT_W{1'b1}};

    ctl_state_e state_q, state_d;
    logic       cap_unlock;
    rsp_code_e  code_q, code_d;
    logic [N-1:0] free_onehot;
    logic         free_any;
    logic [N-1:0] alloc_d, inc_d, dec_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_DECIDE;
            S_DECIDE: state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_unlock <= 1'b0;
            cap_tag    <= '0;
            cap_tid    <= '0;
            code_q     <= RSP_OK;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                cap_unlock <= req_unlock;
                cap_tag    <= req_tag;
                cap_tid    <= req_tid;
            end
            if (state_q == S_DECIDE) code_q <= code_d;
        end
    end

    // lowest-numbered free entry
    always_comb begin
        free_onehot = '0;
        free_any    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!ent_valid[i] && !free_any) begin
                free_onehot[i] = 1'b1;
                free_any       = 1'b1;
            end
        end
    end

    always_comb begin
        code_d  = RSP_OK;
        alloc_d = '0;
        inc_d   = '0;
        dec_d   = '0;
        if (!cap_unlock) begin
            if (hit) begin
                if (owner != cap_tid)        code_d = RSP_HELD;
                else if (depth == MAX_DEPTH) code_d = RSP_ERR;
                else                         inc_d  = hit_vec;
            end else if (free_any) begin
                alloc_d = free_onehot;
            end else begin
                code_d = RSP_FULL;
            end
        end else begin
            if (hit && owner == cap_tid) dec_d  = hit_vec;
            else                         code_d = RSP_ERR;
        end
    end

    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_RESP);
        rsp_code  = code_q;
        ent_alloc = (state_q == S_DECIDE) ? alloc_d : '0;
        ent_inc   = (state_q == S_DECIDE) ? inc_d   : '0;
        ent_dec   = (state_q == S_DECIDE) ? dec_d   : '0;
    end

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    uniq_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R11
    full_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_FULL) |-> (&ent_valid));

    // R9
    err_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_ERR) |-> $stable(ent_valid));

endmodule

// File: rtl/line_lock_table.sv
module line_lock_table
    import lock_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_BYTES = 64,
    parameter int N_ENTRIES  = 4,
    parameter int TID_W      = 2,
    parameter int CNT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_unlock,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TID_W-1:0]  req_tid,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [TID_W-1:0]  lk_tid,
    output logic              lk_foreign,
    output logic [CNT_W-1:0]  lk_depth,
    input  logic              vt_valid,
    input  logic [1:0]        vt_kind,
    input  logic [ADDR_W-1:0] vt_addr,
    output logic              vt_block,
    output logic              vt_flush_fail
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic [N_ENTRIES-1:0]             e_valid;
    logic [N_ENTRIES-1:0][TAG_W-1:0]  e_tag;
    logic [N_ENTRIES-1:0][TID_W-1:0]  e_tid;
    logic [N_ENTRIES-1:0][CNT_W-1:0]  e_cnt;
    logic [N_ENTRIES-1:0]             e_alloc, e_inc, e_dec;

    logic [TAG_W-1:0] cap_tag;
    logic [TID_W-1:0] cap_tid;

    logic                 c_hit, l_hit, v_hit;
    logic [N_ENTRIES-1:0] c_vec, l_vec, v_vec;
    logic [TID_W-1:0]     c_own, l_own, v_own;
    logic [CNT_W-1:0]     c_dep, l_dep, v_dep;

    genvar g;
    generate
        for (g = 0; g < N_ENTRIES; g++) begin : g_ent
            lock_entry #(.TAG_W(TAG_W), .TID_W(TID_W), .CNT_W(CNT_W)) u_ent (
                .clk      (clk),
                .rst_n    (rst_n),
                .do_alloc (e_alloc[g]),
                .do_inc   (e_inc[g]),
                .do_dec   (e_dec[g]),
                .in_tag   (cap_tag),
                .in_tid   (cap_tid),
                .valid    (e_valid[g]),
                .tag      (e_tag[g]),
                .tid      (e_tid[g]),
                .cnt      (e_cnt[g])
            );
        end
    endgenerate

    lock_probe #(.N(N_ENTRIES), .TAG_W(TAG_W), .TID_W(TID_W), .CNT_W(CNT_W)) u_cprobe (
        .key(cap_tag), .e_valid(e_valid), .e_tag(e_tag), .e_tid(e_tid), .e_cnt(e_cnt),
        .hit(c_hit), .hit_vec(c_vec), .owner(c_own), .depth(c_dep)
    );

    lock_probe #(.N(N_ENTRIES), .TAG_W(TAG_W), .TID_W(TID_W), .CNT_W(CNT_W)) u_lprobe (
        .key(lk_addr[ADDR_W-1:OFF_W]), .e_valid(e_valid), .e_tag(e_tag), .e_tid(e_tid),
        .e_cnt(e_cnt), .hit(l_hit), .hit_vec(l_vec), .owner(l_own), .depth(l_dep)
    );

    lock_probe #(.N(N_ENTRIES), .TAG_W(TAG_W), .TID_W(TID_W), .CNT_W(CNT_W)) u_vprobe (
        .key(vt_addr[ADDR_W-1:OFF_W]), .e_valid(e_valid), .e_tag(e_tag), .e_tid(e_tid),
        .e_cnt(e_cnt), .hit(v_hit), .hit_vec(v_vec), .owner(v_own), .depth(v_dep)
    );

    lock_ctrl #(.N(N_ENTRIES), .TAG_W(TAG_W), .TID_W(TID_W), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_unlock (req_unlock),
        .req_tag    (req_addr[ADDR_W-1:OFF_W]),
        .req_tid    (req_tid),
        .ent_valid  (e_valid),
        .hit        (c_hit),
        .hit_vec    (c_vec),
        .owner      (c_own),
        .depth      (c_dep),
        .cap_tag    (cap_tag),
        .cap_tid    (cap_tid),
        .ent_alloc  (e_alloc),
        .ent_inc    (e_inc),
        .ent_dec    (e_dec),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_code   (rsp_code)
    );

    always_comb begin
        lk_foreign    = l_hit && (l_own != lk_tid);
        lk_depth      = l_dep;
        vt_block      = vt_valid && v_hit &&
                        (vt_kind == VT_EVICT || vt_kind == VT_INVAL);
        vt_flush_fail = vt_valid && v_hit && (vt_kind == VT_FLUSH);
    end

    // R13
    flush_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vt_flush_fail |-> (vt_kind == VT_FLUSH));

    // R12
    veto_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vt_block && vt_flush_fail));

    // R7
    foreign_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_foreign |-> (lk_depth != '0));

    // R12
    lk_vt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vt_valid && vt_kind == VT_EVICT && vt_addr == lk_addr) |->
        (vt_block == (lk_depth != '0)));

endmodule

// File: tb/tb_line_lock_table.sv
module tb_line_lock_table;

    localparam int PERIOD = 10;
    localparam int AW  = 16;
    localparam int OFF = 6;
    localparam int NE  = 4;
    localparam int MAXD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_unlock = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_tid = '0;
    logic req_ready, rsp_valid;
    logic [1:0] rsp_code;
    logic [AW-1:0] lk_addr = '0;
    logic [1:0] lk_tid = '0;
    logic lk_foreign;
    logic [1:0] lk_depth;
    logic vt_valid = 1'b0;
    logic [1:0] vt_kind = '0;
    logic [AW-1:0] vt_addr = '0;
    logic vt_block, vt_flush_fail;

    int n_chk = 0, n_fail = 0;
    int m_own[int];
    int m_dep[int];
    int wait_n = 0;
    int p_unlock, p_tag, p_tid;
    bit running = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    line_lock_table dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_unlock(req_unlock), .req_addr(req_addr),
        .req_tid(req_tid), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .lk_addr(lk_addr), .lk_tid(lk_tid),
        .lk_foreign(lk_foreign), .lk_depth(lk_depth), .vt_valid(vt_valid),
        .vt_kind(vt_kind), .vt_addr(vt_addr), .vt_block(vt_block),
        .vt_flush_fail(vt_flush_fail)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    // reference model and cycle compare
    always @(negedge clk) begin
        if (running) begin
            int e_code, lt, vtg, e_dep, e_for, e_blk, e_ff;
            string rq;
            if (wait_n > 0) begin
                wait_n--;
                if (wait_n == 0) begin
                    chk(rsp_valid == 1'b1, "R2", int'(rsp_valid), 1);
                    e_code = 0;
                    if (p_unlock == 0) begin
                        if (m_dep.exists(p_tag)) begin
                            if (m_own[p_tag] != p_tid) begin e_code = 3; rq = "R6"; end
                            else if (m_dep[p_tag] == MAXD) begin e_code = 2; rq = "R10"; end
                            else begin m_dep[p_tag]++; rq = "R5"; end
                        end else if (m_dep.num() == NE) begin
                            e_code = 1; rq = "R11";
                        end else begin
                            m_dep[p_tag] = 1; m_own[p_tag] = p_tid; rq = "R4";
                        end
                    end else begin
                        if (m_dep.exists(p_tag) && m_own[p_tag] == p_tid) begin
                            m_dep[p_tag]--;
                            if (m_dep[p_tag] == 0) begin
                                m_dep.delete(p_tag); m_own.delete(p_tag);
                            end
                            rq = "R8";
                        end else begin
                            e_code = 2; rq = "R9";
                        end
                    end
                    chk(int'(rsp_code) == e_code, rq, int'(rsp_code), e_code);
                end else begin
                    chk(rsp_valid == 1'b0, "R2", int'(rsp_valid), 0);
                    chk(req_ready == 1'b0, "R2", int'(req_ready), 0);
                end
            end else begin
                chk(req_ready == 1'b1, "R2", int'(req_ready), 1);
                chk(rsp_valid == 1'b0, "R2", int'(rsp_valid), 0);
                if (req_valid) begin
                    p_unlock = int'(req_unlock);
                    p_tag    = int'(req_addr) >> OFF;
                    p_tid    = int'(req_tid);
                    wait_n   = 2;
                end
            end
            lt    = int'(lk_addr) >> OFF;
            e_dep = m_dep.exists(lt) ? m_dep[lt] : 0;
            e_for = (m_dep.exists(lt) && m_own[lt] != int'(lk_tid)) ? 1 : 0;
            chk(int'(lk_depth) == e_dep, "R3 R7", int'(lk_depth), e_dep);
            chk(int'(lk_foreign) == e_for, "R7", int'(lk_foreign), e_for);
            vtg   = int'(vt_addr) >> OFF;
            e_blk = (vt_valid && vt_kind < 2 && m_dep.exists(vtg)) ? 1 : 0;
            e_ff  = (vt_valid && vt_kind == 2 && m_dep.exists(vtg)) ? 1 : 0;
            chk(int'(vt_block) == e_blk, "R12", int'(vt_block), e_blk);
            chk(int'(vt_flush_fail) == e_ff, "R13", int'(vt_flush_fail), e_ff);
        end
    end

    task automatic send(input bit unl, input int addr, input int tid);
        @(posedge clk); #1;
        req_valid  = 1'b1;
        req_unlock = unl;
        req_addr   = AW'(addr);
        req_tid    = 2'(tid);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
    endtask

    task automatic probe(input int la, input int lt, input bit vv, input int vk, input int va);
        @(posedge clk); #1;
        lk_addr  = AW'(la);
        lk_tid   = 2'(lt);
        vt_valid = vv;
        vt_kind  = 2'(vk);
        vt_addr  = AW'(va);
        @(posedge clk);
    endtask

    localparam int LA = 'h0040, LB = 'h0080, LC = 'h0100, LD = 'h0400, LE = 'h0800;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
        chk(lk_depth == 2'd0, "R1", int'(lk_depth), 0);
        running = 1'b1;

        probe(LA, 1, 1, 0, LA);
        send(0, LA, 1);            // R4 fresh lock
        send(0, LA + 'h3F, 1);     // R3 R5 same line, other offset
        probe(LA + 5, 1, 1, 1, LA + 'h20);
        probe(LA + 5, 2, 1, 2, LA + 9);
        send(0, LA + 8, 2);        // R6 other thread
        send(1, LA, 2);            // R9 non-owner unlock
        send(1, LB, 0);            // R9 unlock of free line
        send(0, LA, 1);            // depth 3
        send(0, LA, 1);            // R10 overflow
        probe(LA, 3, 1, 0, LB);    // R12 free line not blocked
        probe(LA, 1, 1, 3, LA);    // R13 kind 3 no veto
        send(0, LB, 0);
        send(0, LC, 3);
        send(0, LD + 1, 2);
        send(0, LE, 0);            // R11 full
        probe(LE, 0, 1, 2, LE);
        send(1, LA, 1);
        send(1, LA, 1);
        probe(LA, 2, 1, 1, LA);
        send(1, LA, 1);            // R8 release
        probe(LA, 2, 1, 2, LA);
        send(0, LE, 0);            // now fits
        send(1, LB, 0);
        send(1, LB, 0);            // R9 already freed
        send(1, LC + 'h10, 3);
        send(1, LD, 2);
        send(1, LE, 0);
        probe(LD, 0, 1, 0, LE);
        repeat (2) @(posedge clk);
        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule